// File: doc/BRIEF.md
# Parity-Predicted Adder

This block adds two W-bit operands and a carry-in. Each operand comes with a parity bit, and so does the result. The result parity is computed from the registered sum. A separate predictor works out what that parity should be, using only the operand parity bits and a second carry network that shares no gates with the main adder. The predictor delivers the complement of its prediction. The actual parity and the predicted complement together form a dual-rail error pair. Without a fault this pair always shows two different values, so no comparator is needed.

Parity is even throughout: a parity bit is the XOR of the bits of its word. Results are registered and appear one cycle after the input is accepted, together with a valid flag. A test-only hook can force the carry into one bit of the main adder to a fixed value. This models a stuck carry and shows that the predictor catches it.

Top module: `par_pred_adder`

## Requirements
- R1: One cycle after `in_valid` is sampled high, `sum` equals (`op_a` + `op_b` + `carry_in`) mod 2^W and `carry_out` equals bit W of that total.
- R2: `sum_par` is the XOR of all bits of `sum`.
- R3: `chk_pair[1]` is the actual sum parity and `chk_pair[0]` is the predicted complement. With correct operand parity bits and the fault hook off, the pair is 01 or 10, never 00 or 11.
- R4: `chk_pair[0]` equals NOT(`op_a_par` XOR `op_b_par` XOR the XOR of the carries into bit positions 0 to W-1, with position 0 taking `carry_in`). These carries come from a network separate from the main adder.
- R5: If an operand parity bit does not match its data, the pair registered for that input is 00 or 11. The sum and carry-out stay arithmetically correct.
- R6: `out_valid` is high exactly one cycle after `in_valid` was sampled high. After a cycle with `in_valid` low, `out_valid` is low and `sum`, `sum_par`, `carry_out` and `chk_pair` hold their previous values.
- R7: During reset, `out_valid`, `sum`, `sum_par` and `carry_out` are 0 and `chk_pair` is 01.
- R8: While `flt_en` is high, the carry into main-adder bit `flt_pos` is replaced by `flt_val`, and the predictor is left alone. Example: with W=8, operands 0 and 0, carry-in 0, position 3 forced to 1, the result is `sum` = 8 with pair 11. Forcing a value equal to the true carry changes nothing.
- R9: For W=8, 10110001 (parity 0) plus 00111011 (parity 1) with carry-in 0 gives `sum` 11101100, `sum_par` 1, `carry_out` 0 and pair 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the operands this cycle |
| op_a | input | W | First operand |
| op_a_par | input | 1 | Even parity bit of `op_a` |
| op_b | input | W | Second operand |
| op_b_par | input | 1 | Even parity bit of `op_b` |
| carry_in | input | 1 | Carry into bit 0 |
| flt_en | input | 1 | Test only: enable the carry override |
| flt_pos | input | PW | Test only: bit whose incoming main carry is forced |
| flt_val | input | 1 | Test only: value forced onto that carry |
| out_valid | output | 1 | Registered result is new this cycle |
| sum | output | W | Registered sum |
| sum_par | output | 1 | Even parity of `sum` |
| carry_out | output | 1 | Registered carry out of bit W-1 |
| chk_pair | output | 2 | {actual parity, predicted complement} |

## Verification
All results (`sum`, `carry_out`, `sum_par`, `chk_pair`) and `out_valid` are due one cycle after the input was driven. The driver applies inputs on a falling edge and queues the expected values. The monitor samples on the next falling edge whenever `out_valid` is high and compares the result with the oldest queued entry. The hold behaviour of R6 is checked one further falling edge later, after an idle cycle that carries different operands.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  // A dual-rail pair is a code word when its two rails disagree.
  function automatic logic pair_is_code(input logic [1:0] pr);
    return pr[1] ^ pr[0];
  endfunction

  // Majority of three bits: the carry out of a full-adder cell.
  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction
endpackage

// File: rtl/ppa_main_adder.sv
module ppa_main_adder #(
  parameter int W = 8,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          cin,
  input  logic          flt_en,
  input  logic [PW-1:0] flt_pos,
  input  logic          flt_val,
  output logic [W-1:0]  s,
  output logic          cout
);
  logic [W:0]   c_raw;
  logic [W-1:0] c_eff;

  assign c_raw[0] = cin;

  // Ripple chain; each cell may have its incoming carry overridden.
  for (genvar i = 0; i < W; i++) begin : g_cell
    assign c_eff[i]   = (flt_en && flt_pos == PW'(i)) ? flt_val : c_raw[i];
    assign s[i]       = a[i] ^ b[i] ^ c_eff[i];
    assign c_raw[i+1] = ppa_pkg::maj3(a[i], b[i], c_eff[i]);
  end

  assign cout = c_raw[W];
endmodule

// File: rtl/ppa_carry_shadow.sv
module ppa_carry_shadow #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] carries,
  output logic         cout
);
  // Generate/propagate form, built apart from the main chain.
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   cc;

  assign gen  = a & b;
  assign prop = a | b;
  assign cc[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_gp
    assign cc[i+1] = gen[i] | (prop[i] & cc[i]);
  end

  assign carries = cc[W-1:0];
  assign cout    = cc[W];
endmodule

// File: rtl/ppa_parity_pred.sv
module ppa_parity_pred #(
  parameter int W = 8
) (
  input  logic         pa,
  input  logic         pb,
  input  logic [W-1:0] carries,
  output logic         pred_n
);
  // XOR tree over the shadow carries, then the result is inverted.
  logic [W-1:0] acc;

  assign acc[0] = carries[0];
  for (genvar i = 1; i < W; i++) begin : g_tree
    assign acc[i] = acc[i-1] ^ carries[i];
  end

  assign pred_n = ~(pa ^ pb ^ acc[W-1]);
endmodule

// File: rtl/par_pred_adder.sv
module par_pred_adder #(
  parameter int W = 8,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  op_a,
  input  logic          op_a_par,
  input  logic [W-1:0]  op_b,
  input  logic          op_b_par,
  input  logic          carry_in,
  input  logic          flt_en,
  input  logic [PW-1:0] flt_pos,
  input  logic          flt_val,
  output logic          out_valid,
  output logic [W-1:0]  sum,
  output logic          sum_par,
  output logic          carry_out,
  output logic [1:0]    chk_pair
);
  logic [W-1:0] main_sum;
  logic         main_cout;
  logic [W-1:0] shadow_c;
  logic         shadow_cout;
  logic         pred_n;
  logic         operands_ok;
  logic         ok_q;
  logic         flt_q;

  ppa_main_adder #(.W(W)) u_main (
    .a(op_a), .b(op_b), .cin(carry_in),
    .flt_en(flt_en), .flt_pos(flt_pos), .flt_val(flt_val),
    .s(main_sum), .cout(main_cout)
  );

  ppa_carry_shadow #(.W(W)) u_shadow (
    .a(op_a), .b(op_b), .cin(carry_in),
    .carries(shadow_c), .cout(shadow_cout)
  );

  ppa_parity_pred #(.W(W)) u_pred (
    .pa(op_a_par), .pb(op_b_par), .carries(shadow_c), .pred_n(pred_n)
  );

  // Named event for the assertions: operand parity bits match their data.
  assign operands_ok = ((^op_a) == op_a_par) && ((^op_b) == op_b_par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
      sum_par   <= 1'b0;
      carry_out <= 1'b0;
      chk_pair  <= 2'b01;
      ok_q      <= 1'b1;
      flt_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        sum       <= main_sum;
        sum_par   <= ^main_sum;
        carry_out <= main_cout;
        chk_pair  <= {^main_sum, pred_n};
        ok_q      <= operands_ok;
        flt_q     <= flt_en;
      end
    end
  end

  // R3: good operands with no injected fault give a dual-rail code word.
  p_pair_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ok_q && !flt_q) |-> ppa_pkg::pair_is_code(chk_pair));

  // R5: a bad operand parity bit makes the pair a non-code word.
  p_bad_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !ok_q && !flt_q) |-> !ppa_pkg::pair_is_code(chk_pair));

  // R4: the separate carry networks agree on the carry-out when no fault is injected.
  p_shadow_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_en |-> (main_cout == shadow_cout));

  // R6: out_valid follows in_valid by one cycle.
  p_valid_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R6: after an idle cycle the results hold.
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(sum) && $stable(chk_pair) && $stable(carry_out)));

  // R2: the registered parity matches the registered sum.
  p_sum_par_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (sum_par == ^sum));
endmodule

// File: tb/par_pred_adder_test.sv
module par_pred_adder_test;
  localparam int W  = 8;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic          op_a_par = 1'b0;
  logic [W-1:0]  op_b = '0;
  logic          op_b_par = 1'b0;
  logic          carry_in = 1'b0;
  logic          flt_en = 1'b0;
  logic [PW-1:0] flt_pos = '0;
  logic          flt_val = 1'b0;
  logic          out_valid;
  logic [W-1:0]  sum;
  logic          sum_par;
  logic          carry_out;
  logic [1:0]    chk_pair;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [W-1:0] s;
    logic         co;
    logic         sp;
    logic [1:0]   pr;
    string        req;
  } exp_t;

  exp_t sb[$];

  par_pred_adder #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_a(op_a), .op_a_par(op_a_par), .op_b(op_b), .op_b_par(op_b_par),
    .carry_in(carry_in), .flt_en(flt_en), .flt_pos(flt_pos), .flt_val(flt_val),
    .out_valid(out_valid), .sum(sum), .sum_par(sum_par),
    .carry_out(carry_out), .chk_pair(chk_pair)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Carry into bit i, computed arithmetically from the low i bits.
  function automatic logic carry_at(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic ci, input int i);
    int lo_a = int'(a) % (1 << i);
    int lo_b = int'(b) % (1 << i);
    return ((lo_a + lo_b + int'(ci)) >> i) & 1;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic pa, input logic [W-1:0] b,
                       input logic pb, input logic ci, input string req);
    exp_t e;
    int tot;
    logic cx;
    @(negedge clk);
    op_a = a; op_a_par = pa; op_b = b; op_b_par = pb; carry_in = ci;
    flt_en = 1'b0; in_valid = 1'b1;
    tot = int'(a) + int'(b) + int'(ci);
    e.s  = tot[W-1:0];
    e.co = tot[W];
    e.sp = 1'b0;
    for (int k = 0; k < W; k++) e.sp = e.sp ^ e.s[k];
    cx = 1'b0;
    for (int k = 0; k < W; k++) cx = cx ^ carry_at(a, b, ci, k);
    e.pr  = {e.sp, ~(pa ^ pb ^ cx)};
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic drive_fault(input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [PW-1:0] pos, input logic val,
                             input logic [W-1:0] es, input logic [1:0] epr);
    exp_t e;
    @(negedge clk);
    op_a = a; op_a_par = ^a; op_b = b; op_b_par = ^b; carry_in = 1'b0;
    flt_en = 1'b1; flt_pos = pos; flt_val = val; in_valid = 1'b1;
    e.s = es; e.co = 1'b0; e.sp = epr[1]; e.pr = epr; e.req = "R8";
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; flt_en = 1'b0;
  endtask

  // Monitor: results are due one falling edge after the driving edge.
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      if (sb.size() == 0) begin
        check("R6", "unexpected out_valid", 1, 0);
      end else begin
        e = sb.pop_front();
        check({e.req, "/R1"}, "sum", {1'b0, sum}, {1'b0, e.s});
        check({e.req, "/R1"}, "carry_out", carry_out, e.co);
        check({e.req, "/R2"}, "sum_par", sum_par, e.sp);
        check({e.req, "/R4"}, "chk_pair", chk_pair, e.pr);
        if (e.req == "R3") check("R3", "pair is code", chk_pair[1] ^ chk_pair[0], 1);
        if (e.req == "R5") check("R5", "pair non-code", chk_pair[1] ^ chk_pair[0], 0);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held_s;
    logic [1:0]   held_p;
    repeat (3) @(negedge clk);
    // R7 reset state
    check("R7", "out_valid", out_valid, 0);
    check("R7", "sum", {1'b0, sum}, 0);
    check("R7", "sum_par", sum_par, 0);
    check("R7", "carry_out", carry_out, 0);
    check("R7", "chk_pair", chk_pair, 2'b01);
    rst_n = 1'b1;

    // R9 check vector
    drive(8'b10110001, 1'b0, 8'b00111011, 1'b1, 1'b0, "R9");
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "sum vector", {1'b0, sum}, {1'b0, 8'b11101100});
    check("R9", "pair vector", chk_pair, 2'b10);

    // R6: idle cycle with different operands holds the results
    held_s = sum; held_p = chk_pair;
    op_a = 8'h55; op_b = 8'hAA; carry_in = 1'b1;
    @(negedge clk);
    check("R6", "out_valid idle", out_valid, 0);
    check("R6", "sum held", {1'b0, sum}, {1'b0, held_s});
    check("R6", "pair held", chk_pair, held_p);

    // R1/R3 boundaries: full carry ripple, carry-in, zeros
    drive(8'hFF, 1'b0, 8'h01, 1'b1, 1'b0, "R3");
    drive(8'hFF, 1'b0, 8'hFF, 1'b0, 1'b1, "R3");
    drive(8'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R3");
    drive(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, "R3");
    drive(8'h80, 1'b1, 8'h80, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a = W'((i * 37 + 11) ^ (i << 3));
      logic [W-1:0] b = W'((i * 91 + 5));
      drive(a, ^a, b, ^b, 1'(i & 1), "R3");
    end

    // R5: a wrong operand parity bit
    drive(8'h3C, 1'b1, 8'h12, 1'b0, 1'b0, "R5");
    drive(8'h3C, 1'b0, 8'h13, 1'b0, 1'b1, "R5");

    // R8: stuck carry detected, and a masked override
    drive_fault(8'h00, 8'h00, 3'd3, 1'b1, 8'h08, 2'b11);
    drive_fault(8'h00, 8'h00, 3'd3, 1'b0, 8'h00, 2'b01);
    idle();
    repeat (3) @(negedge clk);
    check("R6", "queue drained", sb.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule